// File: doc/BRIEF.md
# Composite Issue-Slot Writeback Release Sequencer

When an issue slot retires, this block turns it into a stream of scoreboard release requests and per-warp in-flight decrements. The slot can be a composite: its SIMD sets may have been filled by instructions from several warps. The slot carries the following fields:

- the warp ID of the instruction that opened the slot (the primary warp);
- that instruction's destination registers;
- for each set, a valid bit, the owner warp, and the destination registers of the instruction that filled that set.

The block captures the slot in one cycle and raises `busy_o`. It then walks a fixed schedule and emits at most one warp/register release pair per cycle. At the end it emits one counter decrement per distinct owner warp and drops `busy_o`. No new slot is accepted while `busy_o` is high, so the upstream writeback stage stalls on it.

If partitioning is off, or the slot carries no set map, the slot is treated as a plain instruction. Only the primary registers are released, and only the primary warp is decremented. A register index of zero means "no register" and is never released. A set owned by the primary warp is covered by the primary release, so its own tags are not released a second time. Two sets of one non-primary warp may name the same register. The release is then issued twice, which does no harm because clearing a clear scoreboard entry has no effect.

Top module: `wb_composite_release`

## Requirements
- R1: After reset `busy_o`, `rel_valid_o` and `dec_valid_o` are low. A slot is captured on a clock edge where `wb_valid_i` is high and `busy_o` is low, and `busy_o` is high from the next cycle until the stream ends. `wb_valid_i` and all slot inputs are ignored while `busy_o` is high.
- R2: With `partition_en_i`=0 or `has_sets_i`=0, the stream releases every nonzero `prim_dst_i` entry for `prim_warp_i` and emits exactly one decrement, for `prim_warp_i`. All set inputs are ignored.
- R3: In partitioned mode (`partition_en_i`=1 and `has_sets_i`=1), every nonzero `prim_dst_i` entry is released once for `prim_warp_i`.
- R4: In partitioned mode, for each valid set whose owner differs from `prim_warp_i`, every nonzero entry of that set's `set_dst_i` is released for that owner. Duplicates across sets of one warp are emitted once per set.
- R5: A set with `set_valid_i[s]`=0 contributes no release and no decrement.
- R6: Register index 0 is never emitted on `rel_reg_o`.
- R7: In partitioned mode exactly one decrement is emitted per distinct owner warp among valid sets. The primary warp is decremented only if it owns a valid set, and no decrement is emitted if no set is valid.
- R8: Releases and decrements appear only while `busy_o` is high, at most one release per cycle. The stream lasts NUM_OUT+NUM_SETS*NUM_OUT+NUM_SETS cycles in partitioned mode and NUM_OUT+1 cycles otherwise.
- R9: A valid set owned by the primary warp causes no release of its own `set_dst_i` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_valid_i | input | 1 | A completing slot is presented |
| partition_en_i | input | 1 | SIMD set partitioning enabled |
| has_sets_i | input | 1 | Slot carries a set map |
| prim_warp_i | input | WARP_W | Primary warp ID |
| prim_dst_i | input | NUM_OUT*REG_W | Primary destination registers (0 = none) |
| set_valid_i | input | NUM_SETS | Per-set valid |
| set_warp_i | input | NUM_SETS*WARP_W | Per-set owner warp |
| set_dst_i | input | NUM_SETS*NUM_OUT*REG_W | Per-set source-instruction destination registers |
| busy_o | output | 1 | Stream in progress; new slots stall |
| rel_valid_o | output | 1 | Release request valid |
| rel_warp_o | output | WARP_W | Warp of the release |
| rel_reg_o | output | REG_W | Register to release |
| dec_valid_o | output | 1 | In-flight counter decrement valid |
| dec_warp_o | output | WARP_W | Warp whose counter is decremented |

## Verification
The release and decrement streams are checked against slots of several shapes:

- A plain slot whose set inputs hold misleading data, and a partitioned request with no set map. These separate the fallback path from the composite path.
- A composite where the primary warp owns two sets and two other warps own one set each. This separates primary coverage from per-owner release and shows that the decrement is deduplicated.
- A composite with invalid sets and zero register tags. This shows that those contribute nothing.
- A composite where the primary warp owns no set, one warp holds duplicate registers, and a new slot is pushed during the stream. This shows that duplicate releases are issued per set, that the primary warp is not decremented, and that the slot inputs are ignored while busy.

The stream length is compared for every shape.

// File: rtl/wb_rel_pkg.sv
package wb_rel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRIM = 2'd1,
    PH_SETS = 2'd2,
    PH_DEC  = 2'd3
  } wb_phase_e;
endpackage

// File: rtl/wb_owner_scan.sv
// Flags the first valid set of each distinct owner warp.
module wb_owner_scan #(
  parameter int NUM_SETS = 4,
  parameter int WARP_W   = 3
) (
  input  logic [NUM_SETS-1:0]             set_valid_i,
  input  logic [NUM_SETS-1:0][WARP_W-1:0] set_warp_i,
  output logic [NUM_SETS-1:0]             first_o
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_comb begin
      first_o[s] = set_valid_i[s];
      for (int j = 0; j < NUM_SETS; j++) begin
        if (j < s && set_valid_i[j] && (set_warp_i[j] == set_warp_i[s]))
          first_o[s] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/wb_seq_ctrl.sv
module wb_seq_ctrl
  import wb_rel_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_OUT  = 2,
  parameter int SET_IW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  parameter int OUT_IW   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              part_i,
  output wb_phase_e         phase_o,
  output logic [SET_IW-1:0] set_idx_o,
  output logic [OUT_IW-1:0] out_idx_o,
  output logic              busy_o
);
  localparam logic [SET_IW-1:0] LAST_SET = SET_IW'(NUM_SETS - 1);
  localparam logic [OUT_IW-1:0] LAST_OUT = OUT_IW'(NUM_OUT - 1);

  wb_phase_e         phase_q;
  logic [SET_IW-1:0] set_q;
  logic [OUT_IW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      set_q   <= '0;
      out_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_PRIM;
            set_q   <= '0;
            out_q   <= '0;
          end
        end
        PH_PRIM: begin
          if (out_q == LAST_OUT) begin
            out_q   <= '0;
            set_q   <= '0;
            phase_q <= part_i ? PH_SETS : PH_DEC;
          end else begin
            out_q <= out_q + 1'b1;
          end
        end
        PH_SETS: begin
          if (out_q == LAST_OUT) begin
            out_q <= '0;
            if (set_q == LAST_SET) begin
              set_q   <= '0;
              phase_q <= PH_DEC;
            end else begin
              set_q <= set_q + 1'b1;
            end
          end else begin
            out_q <= out_q + 1'b1;
          end
        end
        PH_DEC: begin
          if (!part_i || set_q == LAST_SET) begin
            set_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            set_q <= set_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign set_idx_o = set_q;
  assign out_idx_o = out_q;
  assign busy_o    = (phase_q != PH_IDLE);
endmodule

// File: rtl/wb_release_mux.sv
module wb_release_mux
  import wb_rel_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_OUT  = 2,
  parameter int WARP_W   = 3,
  parameter int REG_W    = 6,
  parameter int SET_IW   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  parameter int OUT_IW   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  wb_phase_e                                  phase_i,
  input  logic [SET_IW-1:0]                          set_idx_i,
  input  logic [OUT_IW-1:0]                          out_idx_i,
  input  logic                                       part_i,
  input  logic [WARP_W-1:0]                          prim_warp_i,
  input  logic [NUM_OUT-1:0][REG_W-1:0]              prim_dst_i,
  input  logic [NUM_SETS-1:0]                        set_valid_i,
  input  logic [NUM_SETS-1:0][WARP_W-1:0]            set_warp_i,
  input  logic [NUM_SETS-1:0][NUM_OUT-1:0][REG_W-1:0] set_dst_i,
  input  logic [NUM_SETS-1:0]                        first_i,
  output logic                                       rel_valid_o,
  output logic [WARP_W-1:0]                          rel_warp_o,
  output logic [REG_W-1:0]                           rel_reg_o,
  output logic                                       dec_valid_o,
  output logic [WARP_W-1:0]                          dec_warp_o
);
  logic [REG_W-1:0]  prim_reg, set_reg;
  logic [WARP_W-1:0] cur_warp;
  logic              cur_valid;

  always_comb begin
    prim_reg  = prim_dst_i[out_idx_i];
    set_reg   = set_dst_i[set_idx_i][out_idx_i];
    cur_warp  = set_warp_i[set_idx_i];
    cur_valid = set_valid_i[set_idx_i];

    rel_valid_o = 1'b0;
    rel_warp_o  = prim_warp_i;
    rel_reg_o   = prim_reg;
    dec_valid_o = 1'b0;
    dec_warp_o  = prim_warp_i;

    case (phase_i)
      PH_PRIM: rel_valid_o = (prim_reg != '0);
      PH_SETS: begin
        rel_warp_o  = cur_warp;
        rel_reg_o   = set_reg;
        // primary-owned sets are covered by the primary release
        rel_valid_o = cur_valid && (cur_warp != prim_warp_i) && (set_reg != '0);
      end
      PH_DEC: begin
        if (part_i) begin
          dec_valid_o = first_i[set_idx_i];
          dec_warp_o  = cur_warp;
        end else begin
          dec_valid_o = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wb_composite_release.sv
module wb_composite_release
  import wb_rel_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int NUM_REGS  = 64,
  parameter int NUM_SETS  = 4,
  parameter int NUM_OUT   = 2,
  parameter int WARP_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  parameter int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        wb_valid_i,
  input  logic                                        partition_en_i,
  input  logic                                        has_sets_i,
  input  logic [WARP_W-1:0]                           prim_warp_i,
  input  logic [NUM_OUT-1:0][REG_W-1:0]               prim_dst_i,
  input  logic [NUM_SETS-1:0]                         set_valid_i,
  input  logic [NUM_SETS-1:0][WARP_W-1:0]             set_warp_i,
  input  logic [NUM_SETS-1:0][NUM_OUT-1:0][REG_W-1:0] set_dst_i,
  output logic                                        busy_o,
  output logic                                        rel_valid_o,
  output logic [WARP_W-1:0]                           rel_warp_o,
  output logic [REG_W-1:0]                            rel_reg_o,
  output logic                                        dec_valid_o,
  output logic [WARP_W-1:0]                           dec_warp_o
);
  localparam int SET_IW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int OUT_IW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic                                        start;
  logic                                        part_q;
  logic [WARP_W-1:0]                           prim_warp_q;
  logic [NUM_OUT-1:0][REG_W-1:0]               prim_dst_q;
  logic [NUM_SETS-1:0]                         set_valid_q;
  logic [NUM_SETS-1:0][WARP_W-1:0]             set_warp_q;
  logic [NUM_SETS-1:0][NUM_OUT-1:0][REG_W-1:0] set_dst_q;
  logic [NUM_SETS-1:0]                         first;
  wb_phase_e                                   phase;
  logic [SET_IW-1:0]                           set_idx;
  logic [OUT_IW-1:0]                           out_idx;
  logic                                        busy;

  assign start = wb_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q      <= 1'b0;
      prim_warp_q <= '0;
      prim_dst_q  <= '0;
      set_valid_q <= '0;
      set_warp_q  <= '0;
      set_dst_q   <= '0;
    end else if (start) begin
      part_q      <= partition_en_i && has_sets_i;
      prim_warp_q <= prim_warp_i;
      prim_dst_q  <= prim_dst_i;
      set_valid_q <= (partition_en_i && has_sets_i) ? set_valid_i : '0;
      set_warp_q  <= set_warp_i;
      set_dst_q   <= set_dst_i;
    end
  end

  wb_owner_scan #(.NUM_SETS(NUM_SETS), .WARP_W(WARP_W)) u_scan (
    .set_valid_i (set_valid_q),
    .set_warp_i  (set_warp_q),
    .first_o     (first)
  );

  wb_seq_ctrl #(
    .NUM_SETS(NUM_SETS), .NUM_OUT(NUM_OUT), .SET_IW(SET_IW), .OUT_IW(OUT_IW)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .part_i    (part_q),
    .phase_o   (phase),
    .set_idx_o (set_idx),
    .out_idx_o (out_idx),
    .busy_o    (busy)
  );

  wb_release_mux #(
    .NUM_SETS(NUM_SETS), .NUM_OUT(NUM_OUT), .WARP_W(WARP_W), .REG_W(REG_W),
    .SET_IW(SET_IW), .OUT_IW(OUT_IW)
  ) u_mux (
    .phase_i     (phase),
    .set_idx_i   (set_idx),
    .out_idx_i   (out_idx),
    .part_i      (part_q),
    .prim_warp_i (prim_warp_q),
    .prim_dst_i  (prim_dst_q),
    .set_valid_i (set_valid_q),
    .set_warp_i  (set_warp_q),
    .set_dst_i   (set_dst_q),
    .first_i     (first),
    .rel_valid_o (rel_valid_o),
    .rel_warp_o  (rel_warp_o),
    .rel_reg_o   (rel_reg_o),
    .dec_valid_o (dec_valid_o),
    .dec_warp_o  (dec_warp_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/wb_composite_release_chk.sv
module wb_composite_release_chk #(
  parameter int NUM_SETS = 4,
  parameter int WARP_W   = 3,
  parameter int REG_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_valid_i,
  input logic              partition_en_i,
  input logic              has_sets_i,
  input logic [WARP_W-1:0] prim_warp_i,
  input logic              busy_o,
  input logic              rel_valid_o,
  input logic [WARP_W-1:0] rel_warp_o,
  input logic [REG_W-1:0]  rel_reg_o,
  input logic              dec_valid_o,
  input logic [WARP_W-1:0] dec_warp_o
);
  logic              mode_q;
  logic [WARP_W-1:0] prim_q;
  logic [7:0]        dec_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      prim_q  <= '0;
      dec_cnt <= '0;
    end else if (wb_valid_i && !busy_o) begin
      mode_q  <= partition_en_i && has_sets_i;
      prim_q  <= prim_warp_i;
      dec_cnt <= '0;
    end else if (dec_valid_o) begin
      dec_cnt <= dec_cnt + 8'd1;
    end
  end

  p_busy_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !busy_o) |=> busy_o);

  p_out_only_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_o || dec_valid_o) |-> busy_o);

  p_no_zero_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_o |-> (rel_reg_o != '0));

  p_plain_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_o && !mode_q) |-> (rel_warp_o == prim_q));

  p_plain_single_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !mode_q) |-> (dec_warp_o == prim_q && dec_cnt == 8'd0));

  p_dec_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_cnt < 8'(NUM_SETS)));
endmodule

bind wb_composite_release wb_composite_release_chk #(
  .NUM_SETS(NUM_SETS), .WARP_W(WARP_W), .REG_W(REG_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wb_valid_i     (wb_valid_i),
  .partition_en_i (partition_en_i),
  .has_sets_i     (has_sets_i),
  .prim_warp_i    (prim_warp_i),
  .busy_o         (busy_o),
  .rel_valid_o    (rel_valid_o),
  .rel_warp_o     (rel_warp_o),
  .rel_reg_o      (rel_reg_o),
  .dec_valid_o    (dec_valid_o),
  .dec_warp_o     (dec_warp_o)
);

// File: tb/wb_composite_release_tb.sv
module wb_composite_release_tb;
  localparam int NUM_WARPS = 8;
  localparam int NUM_REGS  = 64;
  localparam int NUM_SETS  = 4;
  localparam int NUM_OUT   = 2;
  localparam int WARP_W    = 3;
  localparam int REG_W     = 6;
  localparam int LEN_PART  = NUM_OUT + NUM_SETS * NUM_OUT + NUM_SETS;
  localparam int LEN_PLAIN = NUM_OUT + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wb_valid_i = 1'b0;
  logic partition_en_i = 1'b0;
  logic has_sets_i = 1'b0;
  logic [WARP_W-1:0] prim_warp_i = '0;
  logic [NUM_OUT-1:0][REG_W-1:0] prim_dst_i = '0;
  logic [NUM_SETS-1:0] set_valid_i = '0;
  logic [NUM_SETS-1:0][WARP_W-1:0] set_warp_i = '0;
  logic [NUM_SETS-1:0][NUM_OUT-1:0][REG_W-1:0] set_dst_i = '0;
  logic busy_o, rel_valid_o, dec_valid_o;
  logic [WARP_W-1:0] rel_warp_o, dec_warp_o;
  logic [REG_W-1:0] rel_reg_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int exp_rel [NUM_WARPS*NUM_REGS];
  int act_rel [NUM_WARPS*NUM_REGS];
  int exp_dec [NUM_WARPS];
  int act_dec [NUM_WARPS];

  always #10 clk_i = ~clk_i;

  wb_composite_release #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .NUM_SETS(NUM_SETS), .NUM_OUT(NUM_OUT)
  ) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected stream per requirements R2..R7, R9
  task automatic build_expect();
    bit part = partition_en_i && has_sets_i;
    bit seen [NUM_WARPS];
    for (int i = 0; i < NUM_WARPS*NUM_REGS; i++) exp_rel[i] = 0;
    for (int w = 0; w < NUM_WARPS; w++) begin exp_dec[w] = 0; seen[w] = 0; end
    for (int r = 0; r < NUM_OUT; r++)
      if (prim_dst_i[r] != 0) exp_rel[prim_warp_i*NUM_REGS + prim_dst_i[r]]++;
    if (!part) exp_dec[prim_warp_i] = 1;
    else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (!set_valid_i[s]) continue;
        if (!seen[set_warp_i[s]]) begin seen[set_warp_i[s]] = 1; exp_dec[set_warp_i[s]]++; end
        if (set_warp_i[s] == prim_warp_i) continue;
        for (int r = 0; r < NUM_OUT; r++)
          if (set_dst_i[s][r] != 0) exp_rel[set_warp_i[s]*NUM_REGS + set_dst_i[s][r]]++;
      end
    end
  endtask

  task automatic run_slot(input string tag, input bit push_busy);
    int cyc = 0;
    int zero_hits = 0;
    int bad = 0;
    int bad_a = 0, bad_e = 0;
    int exp_len = (partition_en_i && has_sets_i) ? LEN_PART : LEN_PLAIN;
    build_expect();
    for (int i = 0; i < NUM_WARPS*NUM_REGS; i++) act_rel[i] = 0;
    for (int w = 0; w < NUM_WARPS; w++) act_dec[w] = 0;
    wb_valid_i = 1'b1;
    @(negedge clk_i);
    if (push_busy) begin
      // new slot offered while busy (R1): must be ignored
      prim_warp_i = 3'd7; prim_dst_i = {6'd60, 6'd61};
      set_valid_i = '1; set_warp_i = {3'd7, 3'd7, 3'd7, 3'd7};
      set_dst_i = '1;
    end else wb_valid_i = 1'b0;
    while (busy_o && cyc < 1000) begin
      if (rel_valid_o) begin
        if (rel_reg_o == 0) zero_hits++;
        act_rel[rel_warp_o*NUM_REGS + rel_reg_o]++;
      end
      if (dec_valid_o) act_dec[dec_warp_o]++;
      cyc++;
      @(negedge clk_i);
    end
    wb_valid_i = 1'b0;
    check(cyc == exp_len, {"R8 stream length ", tag}, cyc, exp_len);
    check(zero_hits == 0, {"R6 zero register ", tag}, zero_hits, 0);
    for (int i = 0; i < NUM_WARPS*NUM_REGS; i++)
      if (act_rel[i] != exp_rel[i]) begin
        if (bad == 0) begin bad_a = act_rel[i]; bad_e = exp_rel[i]; end
        bad++;
      end
    check(bad == 0, {"R3/R4 release map ", tag}, bad_a, bad_e);
    bad = 0;
    for (int w = 0; w < NUM_WARPS; w++)
      if (act_dec[w] != exp_dec[w]) begin
        if (bad == 0) begin bad_a = act_dec[w]; bad_e = exp_dec[w]; end
        bad++;
      end
    check(bad == 0, {"R7 decrement map ", tag}, bad_a, bad_e);
    @(negedge clk_i);
    check(!busy_o, {"R1 idle after stream ", tag}, busy_o, 0);
  endtask

  task automatic t_reset();
    check(!busy_o, "R1 reset busy", busy_o, 0);
    check(!rel_valid_o, "R1 reset rel_valid", rel_valid_o, 0);
    check(!dec_valid_o, "R1 reset dec_valid", dec_valid_o, 0);
  endtask

  task automatic t_plain_off();  // R2, sets ignored
    partition_en_i = 0; has_sets_i = 1;
    prim_warp_i = 3'd4; prim_dst_i = {6'd12, 6'd9};
    set_valid_i = 4'b1111; set_warp_i = {3'd1, 3'd2, 3'd3, 3'd5};
    set_dst_i = {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8};
    run_slot("R2 partition off", 0);
  endtask

  task automatic t_plain_nomap();  // R2
    partition_en_i = 1; has_sets_i = 0;
    prim_warp_i = 3'd1; prim_dst_i = {6'd0, 6'd33};
    set_valid_i = 4'b0101; set_warp_i = {3'd6, 3'd6, 3'd6, 3'd6};
    set_dst_i = '1;
    run_slot("R2 no set map", 0);
  endtask

  task automatic t_mixed();  // R3 R4 R7 R9
    partition_en_i = 1; has_sets_i = 1;
    prim_warp_i = 3'd2; prim_dst_i = {6'd10, 6'd11};
    set_valid_i = 4'b1111;
    set_warp_i = {3'd6, 3'd5, 3'd2, 3'd2};
    set_dst_i = {6'd40, 6'd41, 6'd30, 6'd31, 6'd50, 6'd51, 6'd52, 6'd53};
    run_slot("R9 mixed owners", 0);
  endtask

  task automatic t_invalid_zero();  // R5 R6
    partition_en_i = 1; has_sets_i = 1;
    prim_warp_i = 3'd0; prim_dst_i = {6'd0, 6'd0};
    set_valid_i = 4'b0110;
    set_warp_i = {3'd7, 3'd3, 3'd4, 3'd1};
    set_dst_i = {6'd20, 6'd21, 6'd0, 6'd22, 6'd23, 6'd0, 6'd24, 6'd25};
    run_slot("R5 invalid sets and zero tags", 0);
  endtask

  task automatic t_dup_stall();  // R1 R4 R7
    partition_en_i = 1; has_sets_i = 1;
    prim_warp_i = 3'd1; prim_dst_i = {6'd14, 6'd0};
    set_valid_i = 4'b1011;
    set_warp_i = {3'd3, 3'd6, 3'd3, 3'd3};
    set_dst_i = {6'd17, 6'd18, 6'd44, 6'd45, 6'd17, 6'd18, 6'd17, 6'd0};
    run_slot("R1 busy stall with duplicates", 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_plain_off();
    t_plain_nomap();
    t_mixed();
    t_invalid_zero();
    t_dup_stall();
    t_mixed();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule